// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes stereo PCM audio from a three-wire serial link (bit clock, channel-select clock and data), with the remote device driving both clocks. It supports three framings: I2S, left-justified and right-justified. All three wires pass through a synchronizer into a fast system clock. The block finds the chosen bit-clock edge in that domain. It then builds one signed word per channel slot and reports each finished word with a one-cycle strobe on its own channel output.

Static configuration inputs set four things: the framing, which bit-clock edge samples the data, which level of the channel-select clock means left, and the word length in right-justified mode. In I2S and left-justified modes the block needs no length setting. Each slot is taken MSB first and placed at the top of the output word. Unused low bits are zero.

Top module: `serial_audio_rx`

## Requirements
- R1: `fmt_sel` selects the framing. Codes 2'b00 and 2'b01 both mean I2S, 2'b10 means left-justified and 2'b11 means right-justified.
- R2: When `lr_swap`=0, a high channel-select level marks the left slot and a low level marks the right slot. When `lr_swap`=1, the mapping is reversed.
- R3: When `latch_rise`=1, data is sampled on rising bit-clock edges. When `latch_rise`=0, data is sampled on falling edges.
- R4: In I2S mode the MSB of a slot is the bit sampled one bit period after the channel-select change. The bit sampled together with the change is the last bit of the previous slot.
- R5: In left-justified mode the MSB is the bit sampled together with the channel-select change. In both MSB-first modes the first min(slot length, 24) bits form the word, MSB-aligned with zeros below. Any bits after the 24th are dropped.
- R6: In right-justified mode `rj_len_sel` sets N: 2'b00=24, 2'b01=20, 2'b10=18, 2'b11=16. The output is the last N bits before the next channel-select change, sign-extended to 24 bits. Earlier padding bits are ignored.
- R7: In right-justified mode, a slot with fewer than N bits gives a word built from all of its bits, sign-extended from the first bit received.
- R8: Each completed slot produces exactly one strobe, one clock cycle wide, on its channel. The left and right strobes are never high together. A channel output changes only in the cycle its strobe is high.
- R9: Reset clears both outputs and both strobes. The slot in progress when reset is released produces no strobe. The first strobe belongs to the first slot that began on a channel-select change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk_i | input | 1 | Serial bit clock |
| lrck_i | input | 1 | Channel-select clock |
| sdata_i | input | 1 | Serial data |
| fmt_sel | input | 2 | Framing select (R1) |
| latch_rise | input | 1 | 1: sample on rising edge, 0: on falling edge |
| lr_swap | input | 1 | Channel-select polarity swap |
| rj_len_sel | input | 2 | Right-justified word length code |
| left_o | output | 24 | Left sample, two's complement |
| left_vld | output | 1 | Left sample strobe |
| right_o | output | 24 | Right sample, two's complement |
| right_vld | output | 1 | Right sample strobe |

## Verification
Two things happen on the same sampled edge at every slot boundary: the finished word of the old slot is released, and the first bit of the new slot is loaded into the emptied shift register. Every scenario sends a left slot and a right slot back to back, followed by a short trailer, so this boundary occurs twice in each run. The test passes only if both received words match the model exactly and each channel strobes exactly once. If the new bit leaked into the released word, or the release used the reloaded register, the mismatch would show in the low or high bits.

// File: rtl/sar_pkg.sv
package sar_pkg;

   typedef enum logic [1:0] {
      FMT_I2S_A = 2'b00,
      FMT_I2S_B = 2'b01,
      FMT_LEFT  = 2'b10,
      FMT_RIGHT = 2'b11
   } sar_fmt_e;

   // right-justified length code to bit count
   function automatic int unsigned rj_bits(input logic [1:0] sel);
      case (sel)
         2'b00:   return 24;
         2'b01:   return 20;
         2'b10:   return 18;
         default: return 16;
      endcase
   endfunction

endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bclk_i,
   input  logic lrck_i,
   input  logic sdata_i,
   input  logic latch_rise,
   output logic lat_pulse,
   output logic lr_bit,
   output logic d_bit
);
   localparam int NSIG = 3;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sar_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [NSIG-1:0] pipe [STAGES];
   logic            bclk_q;
   logic            bclk_now;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) pipe[s] <= '0;
         bclk_q <= 1'b0;
      end else begin
         pipe[0] <= {bclk_i, lrck_i, sdata_i};
         for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
         bclk_q <= pipe[STAGES-1][2];
      end
   end

   assign bclk_now  = pipe[STAGES-1][2];
   assign lat_pulse = latch_rise ? (bclk_now & ~bclk_q) : (~bclk_now & bclk_q);
   assign lr_bit    = pipe[STAGES-1][1];
   assign d_bit     = pipe[STAGES-1][0];

endmodule

// File: rtl/sar_slot_track.sv
module sar_slot_track (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_pulse,
   input  logic lr_bit,
   input  logic i2s_mode,
   output logic bit_en,
   output logic new_slot,
   output logic slot_done,
   output logic done_lr
);
   logic lr_prev;
   logic lr_prev_ok;
   logic cur_lr;
   logic primed;
   logic armed;
   logic slot_lr;
   logic slot_ok;
   logic changed;

   // I2S slots lag the channel clock by one bit
   assign slot_lr = i2s_mode ? lr_prev : lr_bit;
   assign slot_ok = !i2s_mode || lr_prev_ok;
   assign changed = primed && (slot_lr != cur_lr);

   assign bit_en    = bit_pulse && slot_ok;
   assign new_slot  = bit_en && (!primed || changed);
   assign slot_done = bit_en && changed && armed;
   assign done_lr   = cur_lr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lr_prev    <= 1'b0;
         lr_prev_ok <= 1'b0;
         cur_lr     <= 1'b0;
         primed     <= 1'b0;
         armed      <= 1'b0;
      end else if (bit_pulse) begin
         lr_prev    <= lr_bit;
         lr_prev_ok <= 1'b1;
         if (slot_ok) begin
            if (!primed) begin
               primed <= 1'b1;
               cur_lr <= slot_lr;
            end else if (changed) begin
               cur_lr <= slot_lr;
               armed  <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/sar_word_build.sv
module sar_word_build
   import sar_pkg::*;
#(
   parameter int W = 24
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         bit_en,
   input  logic         new_slot,
   input  logic         d_bit,
   input  logic         rj_mode,
   input  logic [1:0]   rj_sel,
   output logic [W-1:0] word
);
   localparam int CW = $clog2(W + 1);

   logic [W-1:0]  sr;
   logic [CW-1:0] cnt;
   logic [CW-1:0] msb_idx;
   logic [CW-1:0] len;
   logic [CW-1:0] eff;
   logic [CW-1:0] sign_idx;

   assign msb_idx  = CW'(W - 1) - cnt;
   assign len      = CW'(rj_bits(rj_sel));
   assign eff      = (cnt < len) ? cnt : len;
   assign sign_idx = (eff == '0) ? '0 : eff - 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr  <= '0;
         cnt <= '0;
      end else if (bit_en) begin
         if (new_slot) begin
            cnt <= CW'(1);
            sr  <= rj_mode ? {{(W-1){1'b0}}, d_bit} : {d_bit, {(W-1){1'b0}}};
         end else if (rj_mode) begin
            sr <= {sr[W-2:0], d_bit};
            if (cnt != CW'(W)) cnt <= cnt + 1'b1;
         end else if (cnt != CW'(W)) begin
            sr[msb_idx] <= d_bit;
            cnt         <= cnt + 1'b1;
         end
      end
   end

   // MSB-first: register as is; right-justified: keep eff low bits, sign-extend
   generate
      for (genvar j = 0; j < W; j++) begin : g_bit
         assign word[j] = !rj_mode ? sr[j]
                        : ((CW'(j) < eff) ? sr[j] : sr[sign_idx]);
      end
   endgenerate

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
   import sar_pkg::*;
#(
   parameter int SAMPLE_W    = 24,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bclk_i,
   input  logic                lrck_i,
   input  logic                sdata_i,
   input  logic [1:0]          fmt_sel,
   input  logic                latch_rise,
   input  logic                lr_swap,
   input  logic [1:0]          rj_len_sel,
   output logic [SAMPLE_W-1:0] left_o,
   output logic                left_vld,
   output logic [SAMPLE_W-1:0] right_o,
   output logic                right_vld
);
   generate
      if (SAMPLE_W < 24) begin : g_bad_width
         $error("serial_audio_rx: SAMPLE_W must be at least 24");
      end
   endgenerate

   sar_fmt_e fmt;
   logic i2s_mode;
   logic rj_mode;
   logic lat_pulse;
   logic lr_bit;
   logic d_bit;
   logic bit_en;
   logic new_slot;
   logic slot_done;
   logic done_lr;
   logic [SAMPLE_W-1:0] word;

   assign fmt      = sar_fmt_e'(fmt_sel);
   assign i2s_mode = (fmt == FMT_I2S_A) || (fmt == FMT_I2S_B);
   assign rj_mode  = (fmt == FMT_RIGHT);

   sar_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .bclk_i     (bclk_i),
      .lrck_i     (lrck_i),
      .sdata_i    (sdata_i),
      .latch_rise (latch_rise),
      .lat_pulse  (lat_pulse),
      .lr_bit     (lr_bit),
      .d_bit      (d_bit)
   );

   sar_slot_track u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_pulse (lat_pulse),
      .lr_bit    (lr_bit),
      .i2s_mode  (i2s_mode),
      .bit_en    (bit_en),
      .new_slot  (new_slot),
      .slot_done (slot_done),
      .done_lr   (done_lr)
   );

   sar_word_build #(.W(SAMPLE_W)) u_build (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_en   (bit_en),
      .new_slot (new_slot),
      .d_bit    (d_bit),
      .rj_mode  (rj_mode),
      .rj_sel   (rj_len_sel),
      .word     (word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_o    <= '0;
         right_o   <= '0;
         left_vld  <= 1'b0;
         right_vld <= 1'b0;
      end else begin
         left_vld  <= 1'b0;
         right_vld <= 1'b0;
         if (slot_done) begin
            if (done_lr ^ lr_swap) begin
               left_o   <= word;
               left_vld <= 1'b1;
            end else begin
               right_o   <= word;
               right_vld <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/sar_rx_chk.sv
module sar_rx_chk #(
   parameter int W = 24
) (
   input logic         clk,
   input logic         rst_n,
   input logic         lat_pulse,
   input logic [1:0]   fmt_sel,
   input logic [1:0]   rj_len_sel,
   input logic [W-1:0] left_o,
   input logic         left_vld,
   input logic [W-1:0] right_o,
   input logic         right_vld
);
   // R8
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(left_vld && right_vld));

   // R8
   left_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      left_vld |=> !left_vld);

   // R8
   right_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      right_vld |=> !right_vld);

   // R8
   left_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !left_vld |-> $stable(left_o));

   // R8
   right_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !right_vld |-> $stable(right_o));

   // R3
   strobe_after_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (left_vld || right_vld) |-> $past(lat_pulse));

   // R6
   rj16_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fmt_sel == 2'b11 && rj_len_sel == 2'b11 && left_vld)
         |-> (left_o[W-1:15] == {(W-15){left_o[15]}}));

   // R9
   always @(posedge clk) begin
      if (!rst_n) begin
         reset_quiet_chk: assert (!left_vld && !right_vld && left_o == '0 && right_o == '0);
      end
   end

endmodule

bind serial_audio_rx sar_rx_chk #(.W(SAMPLE_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .lat_pulse  (lat_pulse),
   .fmt_sel    (fmt_sel),
   .rj_len_sel (rj_len_sel),
   .left_o     (left_o),
   .left_vld   (left_vld),
   .right_o    (right_o),
   .right_vld  (right_vld)
);

// File: tb/serial_audio_rx_tb.sv
`timescale 1ns/1ps
module serial_audio_rx_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bclk = 1'b0;
   logic        lrck = 1'b0;
   logic        sdata = 1'b0;
   logic [1:0]  fmt_sel = 2'b00;
   logic        latch_rise = 1'b1;
   logic        lr_swap = 1'b0;
   logic [1:0]  rj_len_sel = 2'b00;
   logic [23:0] left_o, right_o;
   logic        left_vld, right_vld;

   int n_chk = 0;
   int n_fail = 0;
   int lcnt = 0;
   int rcnt = 0;
   logic [23:0] lcap = '0;
   logic [23:0] rcap = '0;

   always #2.5 clk = ~clk;

   serial_audio_rx u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .bclk_i     (bclk),
      .lrck_i     (lrck),
      .sdata_i    (sdata),
      .fmt_sel    (fmt_sel),
      .latch_rise (latch_rise),
      .lr_swap    (lr_swap),
      .rj_len_sel (rj_len_sel),
      .left_o     (left_o),
      .left_vld   (left_vld),
      .right_o    (right_o),
      .right_vld  (right_vld)
   );

   always @(negedge clk) begin
      if (left_vld) begin lcnt++; lcap = left_o; end
      if (right_vld) begin rcnt++; rcap = right_o; end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic stream_bit(input logic [1:0] fmt, input logic [23:0] w,
                                       input int nbits, input int slot, input logic pad, input int i);
      if (fmt != 2'b11) return (i < nbits) ? w[nbits-1-i] : pad;
      return (i >= slot - nbits) ? w[slot-1-i] : pad;
   endfunction

   function automatic logic [23:0] exp_word(input logic [1:0] fmt, input logic [23:0] w,
                                            input int nbits, input int slot, input logic pad,
                                            input logic [1:0] rsel);
      logic [23:0] r = '0;
      int n;
      int eff;
      if (fmt != 2'b11) begin
         for (int k = 0; k < 24; k++)
            if (k < slot) r[23-k] = stream_bit(fmt, w, nbits, slot, pad, k);
      end else begin
         n = (rsel == 2'b00) ? 24 : (rsel == 2'b01) ? 20 : (rsel == 2'b10) ? 18 : 16;
         eff = (slot < n) ? slot : n;
         for (int j = 0; j < 24; j++)
            r[j] = (j < eff) ? stream_bit(fmt, w, nbits, slot, pad, slot-1-j)
                             : stream_bit(fmt, w, nbits, slot, pad, slot-eff);
      end
      return r;
   endfunction

   task automatic bit_out(input logic lr, input logic d);
      @(negedge clk);
      bclk = ~latch_rise;
      lrck = lr;
      sdata = d;
      repeat (8) @(negedge clk);
      bclk = latch_rise;
      repeat (7) @(negedge clk);
   endtask

   task automatic apply_reset(input logic [1:0] fmt, input logic swap, input logic rise,
                              input logic [1:0] rsel);
      rst_n = 1'b0;
      fmt_sel = fmt;
      lr_swap = swap;
      latch_rise = rise;
      rj_len_sel = rsel;
      bclk = ~rise;
      lrck = swap;
      sdata = 1'b0;
      repeat (4) @(negedge clk);
      lcnt = 0;
      rcnt = 0;
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   // one left and one right slot, preceded by a partial slot and followed by a trailer
   task automatic run_case(input string req, input logic [1:0] fmt, input logic swap,
                           input logic rise, input logic [1:0] rsel,
                           input logic [23:0] wl, input logic [23:0] wr,
                           input int nbits, input int slot, input logic pad);
      logic lv = ~swap;
      logic rv = swap;
      logic i2s = ~fmt[1];
      apply_reset(fmt, swap, rise, rsel);
      for (int k = 0; k < 4; k++) bit_out((i2s && k == 3) ? lv : rv, 1'b1);
      for (int i = 0; i < slot; i++)
         bit_out((i2s && i == slot-1) ? rv : lv, stream_bit(fmt, wl, nbits, slot, pad, i));
      for (int i = 0; i < slot; i++)
         bit_out((i2s && i == slot-1) ? lv : rv, stream_bit(fmt, wr, nbits, slot, pad, i));
      bit_out(lv, 1'b0);
      bit_out(lv, 1'b0);
      repeat (10) @(negedge clk);
      chk({req, " R8 left strobe count"}, lcnt, 1);
      chk({req, " R8 right strobe count"}, rcnt, 1);
      chk({req, " left word"}, {8'h0, lcap}, {8'h0, exp_word(fmt, wl, nbits, slot, pad, rsel)});
      chk({req, " right word"}, {8'h0, rcap}, {8'h0, exp_word(fmt, wr, nbits, slot, pad, rsel)});
   endtask

   task automatic reset_state_case();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R9 reset left_o", {8'h0, left_o}, 32'h0);
      chk("R9 reset right_o", {8'h0, right_o}, 32'h0);
      chk("R9 reset strobes", {30'h0, left_vld, right_vld}, 32'h0);
   endtask

   // a partial slot and one boundary only: nothing complete, no strobe
   task automatic partial_case();
      apply_reset(2'b10, 1'b0, 1'b1, 2'b00);
      for (int k = 0; k < 5; k++) bit_out(1'b0, 1'b1);
      for (int k = 0; k < 6; k++) bit_out(1'b1, 1'b1);
      repeat (10) @(negedge clk);
      chk("R9 no strobe for partial slot", lcnt + rcnt, 0);
   endtask

   initial begin
      #(5.0 * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      reset_state_case();
      run_case("R5 R3 LJ 24b rise",        2'b10, 1'b0, 1'b1, 2'b00, 24'hA5C3E1, 24'h5A3C1E, 24, 24, 1'b0);
      run_case("R4 R1 I2S code00 slot32",  2'b00, 1'b0, 1'b1, 2'b00, 24'h123456, 24'hFEDCBA, 24, 32, 1'b0);
      run_case("R4 R1 R5 I2S code01 16b",  2'b01, 1'b0, 1'b1, 2'b00, 24'h00BEEF, 24'h001234, 16, 16, 1'b0);
      run_case("R2 R3 LJ fall swap 20b",   2'b10, 1'b1, 1'b0, 2'b00, 24'h0ABCDE, 24'h054321, 20, 32, 1'b0);
      run_case("R5 LJ drop past 24",       2'b10, 1'b0, 1'b1, 2'b00, 24'h0F0F0F, 24'hF0F0F0, 24, 32, 1'b1);
      run_case("R2 R3 R4 I2S fall swap",   2'b00, 1'b1, 1'b0, 2'b00, 24'h800001, 24'h7FFFFE, 24, 24, 1'b0);
      run_case("R6 RJ 16b",                2'b11, 1'b0, 1'b1, 2'b11, 24'h008001, 24'h007FFE, 16, 32, 1'b0);
      run_case("R6 RJ 20b",                2'b11, 1'b0, 1'b1, 2'b01, 24'h012345, 24'h080000, 20, 32, 1'b1);
      run_case("R6 RJ 18b",                2'b11, 1'b1, 1'b0, 2'b10, 24'h020001, 24'h01FFFF, 18, 24, 1'b1);
      run_case("R6 RJ 24b",                2'b11, 1'b0, 1'b1, 2'b00, 24'h800000, 24'h3C5A69, 24, 32, 1'b1);
      run_case("R7 RJ short slot",         2'b11, 1'b0, 1'b1, 2'b00, 24'h00C000, 24'h004000, 16, 16, 1'b0);
      partial_case();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule